// File: doc/BRIEF.md
# Address match breakpoint comparator

This block watches instruction fetches and data accesses of a processor core and decides, before the fetch or access takes effect, whether a debug trigger requests a breakpoint exception. It receives the stored words of every trigger (a control word, an address word and a qualifier word) and evaluates all triggers in parallel in the same cycle. An address-match trigger can watch execution at one address, or loads and stores that touch a byte range starting at its address word.

Two trigger flavours share the comparator. The older flavour carries only plain privilege-mode enables and never fires while the core runs virtualized. The newer flavour carries a second group of enables that is used instead of the plain group while virtualization is active. A qualifier word can also tie every match to a machine context value. When several triggers hit together the lowest index wins. Its index and its address word are reported one clock later, together with the exception request.

Top module: `addr_match_bkpt`

## Requirements
- R1: While reset is asserted and in the first cycle after it, exc_req, exc_addr and exc_idx are all zero.
- R2: A trigger takes part in matching only when its type field, control bits [31:28], is 2 or 6, at least one of its privilege enables is set (bits 3, 4 and 6, plus bits 23 and 24 for type 6), and at least one of its access enables is set (bit 0 load, bit 1 store, bit 2 execute).
- R3: A type 2 trigger passes the privilege test only when control bit 3+priv is set and virt is low. It never fires while virt is high.
- R4: A type 6 trigger tests control bit 23+priv while virt is high and bit 3+priv while virt is low.
- R5: An execute trigger fires when fetch_valid is high and fetch_pc equals its address word.
- R6: A load trigger fires on mem_rd and a store trigger on mem_wr when the byte range [mem_addr, mem_addr+2^mem_size) overlaps [address word, address word+trigger width). A read does not fire a store-only trigger, nor a write a load-only trigger.
- R7: The trigger width comes from control bits [17:16] for type 2 (0 and 3 give 4 bytes, 1 gives 1, 2 gives 2) and from bits [19:16] for type 6 (1 gives 1, 2 gives 2, 3 gives 4, every other code gives 8).
- R8: When qualifier bits [31:29] equal 4, a match also requires qualifier bits [7:0] to equal mctx. Any other value of that field applies no context check.
- R9: Among triggers that fire in the same cycle the lowest index is reported in exc_idx, and exc_addr is that trigger's address word. With no hit, exc_addr and exc_idx are zero.
- R10: The outputs reflect the inputs sampled at the previous rising clock edge, with exactly one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_ctrl | input | NTRIG x XLEN | Control word of each trigger |
| trig_addr | input | NTRIG x XLEN | Address word of each trigger |
| trig_qual | input | NTRIG x XLEN | Context qualifier word of each trigger |
| fetch_valid | input | 1 | An instruction fetch is presented |
| fetch_pc | input | XLEN | Address of the fetched instruction |
| mem_rd | input | 1 | Data read presented |
| mem_wr | input | 1 | Data write presented |
| mem_addr | input | XLEN | Lowest byte address of the data access |
| mem_size | input | 2 | Log2 of the access width in bytes |
| priv | input | 2 | Current privilege level (0 user, 1 supervisor, 3 machine) |
| virt | input | 1 | Virtualization active |
| mctx | input | CTXW | Machine context value |
| exc_req | output | 1 | Breakpoint exception request |
| exc_addr | output | XLEN | Address word of the winning trigger |
| exc_idx | output | log2(NTRIG) | Index of the winning trigger |

## Verification
Execute matches are tried at the exact address and one word off, which separates an equality compare from a range compare. Data accesses are placed just inside and just outside each edge of the trigger window with several access widths and every size code, which tells an overlap test from a start-address test and exposes a wrong default width. Privilege and virtualization are swept over both enable groups of both trigger types, the context qualifier is tried with matching and differing values under both select settings, and two triggers hitting at once show that the lower index wins.

// File: rtl/addr_match_bkpt.sv
module addr_match_bkpt #(
  parameter int NTRIG = 4,
  parameter int XLEN  = 32,
  parameter int CTXW  = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NTRIG-1:0][XLEN-1:0]        trig_ctrl,
  input  logic [NTRIG-1:0][XLEN-1:0]        trig_addr,
  input  logic [NTRIG-1:0][XLEN-1:0]        trig_qual,
  input  logic                              fetch_valid,
  input  logic [XLEN-1:0]                   fetch_pc,
  input  logic                              mem_rd,
  input  logic                              mem_wr,
  input  logic [XLEN-1:0]                   mem_addr,
  input  logic [1:0]                        mem_size,
  input  logic [1:0]                        priv,
  input  logic                              virt,
  input  logic [CTXW-1:0]                   mctx,
  output logic                              exc_req,
  output logic [XLEN-1:0]                   exc_addr,
  output logic [$clog2(NTRIG)-1:0]          exc_idx
);
  localparam int IW = $clog2(NTRIG);
  localparam int AW = XLEN + 1;

  logic [NTRIG-1:0] hit;
  logic [AW-1:0]    acc_lo, acc_hi;

  assign acc_lo = {1'b0, mem_addr};
  assign acc_hi = acc_lo + {{(AW-4){1'b0}}, 4'd1 << mem_size};

  for (genvar g = 0; g < NTRIG; g++) begin : g_trig
    logic [XLEN-1:0] ctl;
    logic            is2, is6, armed, priv_ok, ctx_ok, exec_hit, data_hit;
    logic [3:0]      plain_en, virt_en, width;
    logic [AW-1:0]   win_lo, win_hi;

    assign ctl      = trig_ctrl[g];
    assign is2      = ctl[XLEN-1:XLEN-4] == 4'd2;
    assign is6      = ctl[XLEN-1:XLEN-4] == 4'd6;
    assign plain_en = ctl[6:3];
    assign virt_en  = ctl[26:23];
    assign armed    = (|ctl[2:0]) &&
                      ((is2 && (ctl[3] || ctl[4] || ctl[6])) ||
                       (is6 && (ctl[3] || ctl[4] || ctl[6] || ctl[23] || ctl[24])));
    assign priv_ok  = is2 ? (!virt && plain_en[priv])
                          : (virt ? virt_en[priv] : plain_en[priv]);
    assign ctx_ok   = (trig_qual[g][XLEN-1:XLEN-3] != 3'd4) ||
                      (trig_qual[g][CTXW-1:0] == mctx);

    always_comb begin
      if (is2) begin
        case (ctl[17:16])
          2'd1:    width = 4'd1;
          2'd2:    width = 4'd2;
          default: width = 4'd4;
        endcase
      end else begin
        case (ctl[19:16])
          4'd1:    width = 4'd1;
          4'd2:    width = 4'd2;
          4'd3:    width = 4'd4;
          default: width = 4'd8;
        endcase
      end
    end

    assign win_lo   = {1'b0, trig_addr[g]};
    assign win_hi   = win_lo + {{(AW-4){1'b0}}, width};
    assign exec_hit = fetch_valid && ctl[2] && (fetch_pc == trig_addr[g]);
    assign data_hit = ((mem_rd && ctl[0]) || (mem_wr && ctl[1])) &&
                      (acc_lo < win_hi) && (win_lo < acc_hi);
    assign hit[g]   = armed && priv_ok && ctx_ok && (exec_hit || data_hit);
  end

  logic [IW-1:0]   win_idx;
  logic [XLEN-1:0] win_addr;

  always_comb begin
    win_idx  = '0;
    win_addr = '0;
    for (int i = NTRIG - 1; i >= 0; i--) begin
      if (hit[i]) begin
        win_idx  = IW'(i);
        win_addr = trig_addr[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exc_req  <= 1'b0;
      exc_addr <= '0;
      exc_idx  <= '0;
    end else begin
      exc_req  <= |hit;
      exc_addr <= win_addr;
      exc_idx  <= win_idx;
    end
  end
endmodule

// File: rtl/addr_match_bkpt_chk.sv
module addr_match_bkpt_chk #(
  parameter int NTRIG = 4,
  parameter int XLEN  = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NTRIG-1:0][XLEN-1:0] trig_ctrl,
  input logic [NTRIG-1:0][XLEN-1:0] trig_addr,
  input logic                       fetch_valid,
  input logic                       mem_rd,
  input logic                       mem_wr,
  input logic                       virt,
  input logic                       exc_req,
  input logic [XLEN-1:0]            exc_addr,
  input logic [$clog2(NTRIG)-1:0]   exc_idx
);
  logic [NTRIG-1:0][XLEN-1:0] prev_addr;
  logic all_t2, none_enabled;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_addr <= '0;
    else        prev_addr <= trig_addr;
  end

  always_comb begin
    all_t2       = 1'b1;
    none_enabled = 1'b1;
    for (int i = 0; i < NTRIG; i++) begin
      if (trig_ctrl[i][XLEN-1:XLEN-4] != 4'd2) all_t2 = 1'b0;
      if (|trig_ctrl[i][2:0]) none_enabled = 1'b0;
    end
  end

  assert_quiet_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_valid && !mem_rd && !mem_wr) |=> !exc_req);

  assert_type2_virt_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (virt && all_t2) |=> !exc_req);

  assert_unarmed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    none_enabled |=> !exc_req);

  assert_addr_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> exc_addr == prev_addr[exc_idx]);

  assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_req |-> (exc_addr == '0 && exc_idx == '0));
endmodule

bind addr_match_bkpt addr_match_bkpt_chk #(.NTRIG(NTRIG), .XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig_ctrl(trig_ctrl), .trig_addr(trig_addr),
  .fetch_valid(fetch_valid), .mem_rd(mem_rd), .mem_wr(mem_wr), .virt(virt),
  .exc_req(exc_req), .exc_addr(exc_addr), .exc_idx(exc_idx)
);

// File: tb/test_addr_match_bkpt.sv
module test_addr_match_bkpt;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NT-1:0][31:0] tc, ta, tq;
  logic        fv, rd, wr, virt;
  logic [31:0] pc, ma;
  logic [1:0]  msz, priv;
  logic [7:0]  mctx;
  logic        exc_req;
  logic [31:0] exc_addr;
  logic [1:0]  exc_idx;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_match_bkpt i_addr_match_bkpt (
    .clk(clk), .rst_n(rst_n), .trig_ctrl(tc), .trig_addr(ta), .trig_qual(tq),
    .fetch_valid(fv), .fetch_pc(pc), .mem_rd(rd), .mem_wr(wr), .mem_addr(ma),
    .mem_size(msz), .priv(priv), .virt(virt), .mctx(mctx),
    .exc_req(exc_req), .exc_addr(exc_addr), .exc_idx(exc_idx)
  );

  function automatic logic [31:0] c2(input logic [3:0] modes, input logic [2:0] xsl,
                                     input logic [1:0] sz);
    logic [31:0] v = '0;
    v[31:28] = 4'd2; v[6:3] = modes; v[2:0] = xsl; v[17:16] = sz;
    return v;
  endfunction

  function automatic logic [31:0] c6(input logic [3:0] modes, input logic [1:0] vmodes,
                                     input logic [2:0] xsl, input logic [3:0] sz);
    logic [31:0] v = '0;
    v[31:28] = 4'd6; v[6:3] = modes; v[24:23] = vmodes; v[2:0] = xsl; v[19:16] = sz;
    return v;
  endfunction

  // behavioural reference: first firing trigger in index order
  task automatic model(output bit r, output int idx, output logic [31:0] a);
    r = 0; idx = 0; a = '0;
    for (int t = 0; t < NT; t++) begin
      logic [31:0] w = tc[t];
      int typ = int'(w[31:28]);
      bit anymode, pok, fire;
      longint tlo, thi, alo, ahi;
      int width;
      if (typ != 2 && typ != 6) continue;
      anymode = w[3] | w[4] | w[6] | ((typ == 6) && (w[23] | w[24]));
      if (!anymode || w[2:0] == 3'b000) continue;
      if (typ == 2) pok = !virt && w[3 + int'(priv)];
      else          pok = w[(virt ? 23 : 3) + int'(priv)];
      if (!pok) continue;
      if (tq[t][31:29] == 3'd4 && tq[t][7:0] != mctx) continue;
      if (typ == 2) width = (w[17:16] == 2'd1) ? 1 : (w[17:16] == 2'd2) ? 2 : 4;
      else case (int'(w[19:16])) 1: width = 1; 2: width = 2; 3: width = 4; default: width = 8; endcase
      tlo = longint'(ta[t]); thi = tlo + width;
      alo = longint'(ma);    ahi = alo + (longint'(1) << msz);
      fire = (fv && w[2] && pc == ta[t]) ||
             (((rd && w[0]) || (wr && w[1])) && alo < thi && tlo < ahi);
      if (fire) begin r = 1; idx = t; a = ta[t]; return; end
    end
  endtask

  task automatic cyc(input string tag);
    bit er; int ei; logic [31:0] ea;
    model(er, ei, ea);
    @(posedge clk); @(negedge clk);
    checks++;
    if (exc_req !== er || int'(exc_idx) != ei || exc_addr !== ea) begin
      errors++;
      $display("FAIL %s: got req=%0b idx=%0d addr=%h, expected req=%0b idx=%0d addr=%h",
               tag, exc_req, exc_idx, exc_addr, er, ei, ea);
    end
  endtask

  task automatic clr();
    tc = '0; ta = '0; tq = '0; fv = 0; rd = 0; wr = 0; virt = 0;
    pc = '0; ma = '0; msz = 2'd0; priv = 2'd3; mctx = '0;
  endtask

  initial begin
    clr();
    repeat (3) @(negedge clk);
    checks++;
    if (exc_req !== 1'b0 || exc_addr !== '0 || exc_idx !== '0) begin
      errors++;
      $display("FAIL R1: got req=%0b idx=%0d addr=%h, expected zeros", exc_req, exc_idx, exc_addr);
    end
    rst_n = 1'b1;
    fv = 1; cyc("R1 first cycle after reset");

    // R2: type and enables
    ta[0] = 32'h100; pc = 32'h100;
    cyc("R2 type 0 never fires");
    tc[0] = c2(4'b1000, 3'b100, 2'd0); cyc("R5 exec hit");
    pc = 32'h104; cyc("R5 exec miss by one word");
    pc = 32'h100;
    tc[0] = c2(4'b0000, 3'b100, 2'd0); cyc("R2 no mode bit");
    tc[0] = c2(4'b1000, 3'b000, 2'd0); cyc("R2 no access bit");
    tc[0] = c2(4'b1000, 3'b100, 2'd0); tc[0][31:28] = 4'd3; cyc("R2 other type");

    // R3 / R4 privilege
    tc[0] = c2(4'b1000, 3'b100, 2'd0); priv = 2'd0; cyc("R3 user, machine only");
    tc[0] = c2(4'b0001, 3'b100, 2'd0); cyc("R3 user enabled");
    virt = 1; cyc("R3 type2 virtualized");
    tc[0] = c6(4'b0000, 2'b01, 3'b100, 4'd0); cyc("R4 type6 virtual user");
    priv = 2'd1; cyc("R4 virtual supervisor disabled");
    virt = 0; priv = 2'd0; cyc("R4 plain user uses plain group");
    tc[0] = c6(4'b0001, 2'b00, 3'b100, 4'd0); cyc("R4 plain user enabled");
    virt = 1; cyc("R4 virtual ignores plain group");
    clr(); cyc("R10 idle after hit");

    // R6 / R7 data windows
    ta[1] = 32'h200; tc[1] = c2(4'b1000, 3'b001, 2'd0);
    rd = 1; ma = 32'h203; cyc("R7 type2 default width last byte");
    ma = 32'h204; cyc("R7 type2 default width past end");
    ma = 32'h1FE; msz = 2'd2; cyc("R6 overlap from below");
    ma = 32'h1FC; cyc("R6 ends just below window");
    ma = 32'h200; msz = 2'd0; rd = 0; wr = 1; cyc("R6 write on load-only");
    tc[1] = c2(4'b1000, 3'b010, 2'd1); cyc("R6 store hit width 1");
    ma = 32'h201; cyc("R7 type2 code 1 width 1");
    tc[1] = c2(4'b1000, 3'b010, 2'd2); cyc("R7 type2 code 2 width 2");
    wr = 0; rd = 1; cyc("R6 read on store-only");
    tc[1] = c6(4'b1000, 2'b00, 3'b001, 4'd0); ma = 32'h207; cyc("R7 type6 default width 8");
    ma = 32'h208; cyc("R7 type6 past 8");
    tc[1] = c6(4'b1000, 2'b00, 3'b001, 4'd2); ma = 32'h202; cyc("R7 type6 code 2 miss");
    tc[1] = c6(4'b1000, 2'b00, 3'b001, 4'd3); cyc("R7 type6 code 3 hit");
    tc[1] = c6(4'b1000, 2'b00, 3'b001, 4'd9); ma = 32'h207; cyc("R7 type6 unsupported code width 8");
    ma = 32'h1F8; msz = 2'd3; cyc("R6 8 byte access ends below");

    // R8 context
    clr(); ta[2] = 32'h500; tc[2] = c2(4'b1000, 3'b100, 2'd0); fv = 1; pc = 32'h500;
    tq[2] = {3'd4, 21'd0, 8'h5A}; mctx = 8'h5A; cyc("R8 context equal");
    mctx = 8'h5B; cyc("R8 context differs");
    tq[2][31:29] = 3'd0; cyc("R8 select 0 no check");
    tq[2][31:29] = 3'd2; cyc("R8 select other no check");

    // R9 priority
    clr(); fv = 1; pc = 32'h300; rd = 1; ma = 32'h400;
    ta[1] = 32'h300; tc[1] = c2(4'b1000, 3'b100, 2'd0);
    ta[3] = 32'h400; tc[3] = c6(4'b1000, 2'b00, 3'b001, 4'd0);
    cyc("R9 lowest index wins");
    tc[1] = '0; cyc("R9 higher index alone");
    rd = 0; cyc("R10 strobe removed");
    cyc("R10 quiet");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule